// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside an I2C master engine and watches the shared bus. It brings the raw SDA and SCL pins into the clock domain through a synchronizer chain and detects START conditions (SDA falls while SCL is high) and STOP conditions (SDA rises while SCL is high). From these it keeps a bus-busy flag. When the local master asks to begin a transfer, the block lets it go at once on a quiet bus. On a busy bus it holds the request until a foreign STOP arrives, then counts a bus-free interval equal to the programmed SCL low period before it signals the master to generate START.

While the local master drives address or data bits, the engine marks each such bit with a valid strobe and supplies the value it puts on SDA. On every SCL rising edge the block compares that value with the line. A released SDA (a 1) that reads back as 0 means arbitration is lost. The block then raises a one-cycle loss event, halts SCL generation until the bus is released, asks for a TX FIFO flush and for the start, restart and stop command bits to be cleared, and sets a sticky error flag and a sticky lockout flag. It also follows the address bits of the frame in progress. If this node lost arbitration in that frame and the winner's seven address bits equal the node's own slave address, it reports a switch to slave mode. This can happen in the same address byte in which arbitration was lost.

Top module: `i2c_arb_monitor`

## Requirements
- R1: The bus-busy output rises three clock cycles after an SDA fall with SCL high on the raw pins, and falls three cycles after an SDA rise with SCL high. SDA changes while SCL is low do not alter it.
- R2: A loss event (arb_lost_o, fifo_flush_o and cmd_clear_o all high for exactly one cycle) occurs when an SCL rising edge is seen while mst_en_i and bit_valid_i are 1, sda_drive_i is 1 and the sampled SDA is 0. It is visible three cycles after the raw SCL rise.
- R3: No loss event occurs for any other combination of mst_en_i, bit_valid_i, sda_drive_i and sampled SDA.
- R4: scl_halt_o goes high together with a loss event and stays high until the next STOP condition has been detected.
- R5: arb_err_o is set by a loss event and stays set until a one-cycle err_clr_i pulse. A clear does not touch tx_lock_o.
- R6: tx_lock_o is set by a loss event and stays set until a lock_clr_i pulse. While it is set, a start request never produces start_go_o.
- R7: With mst_en_i high and the bus not busy, a start request sampled on a clock edge gives a one-cycle start_go_o pulse right after that edge. With mst_en_i low, no pulse is produced.
- R8: A start request made while the bus is busy waits for a STOP. start_go_o then pulses L clock cycles after bus_busy_o falls, where L = scl_low_cnt_i and L is at least 1.
- R9: A waiting start request is dropped if a loss event occurs before it is granted. No start_go_o follows the later STOP.
- R10: After a START, if this node loses arbitration at or before the seventh SCL rise, and the seven bits sampled on the first seven rises (MSB first) equal own_addr_i, slave_sel_o pulses for one cycle three cycles after the seventh raw SCL rise.
- R11: slave_sel_o stays low when the node lost no arbitration in that frame, or when the seven address bits differ from own_addr_i.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_en_i | input | 1 | Master mode enabled |
| sda_raw_i | input | 1 | Raw SDA pin level |
| scl_raw_i | input | 1 | Raw SCL pin level |
| own_addr_i | input | ADDR_W | This node's slave address |
| scl_low_cnt_i | input | CNT_W | SCL low period in clock cycles (bus-free time) |
| start_req_i | input | 1 | One-cycle request to start a transfer |
| sda_drive_i | input | 1 | Value the master puts on SDA (1 = released) |
| bit_valid_i | input | 1 | Current bit is driven by this node |
| err_clr_i | input | 1 | Clears the arbitration-error flag |
| lock_clr_i | input | 1 | Clears the TX lockout flag |
| bus_busy_o | output | 1 | Bus between START and STOP |
| start_go_o | output | 1 | Pulse: generate START now |
| arb_lost_o | output | 1 | Pulse: arbitration lost |
| scl_halt_o | output | 1 | Stop driving SCL and SDA |
| arb_err_o | output | 1 | Sticky arbitration-error flag |
| tx_lock_o | output | 1 | Sticky TX lockout flag |
| fifo_flush_o | output | 1 | Pulse: flush TX FIFO |
| cmd_clear_o | output | 1 | Pulse: clear start/restart/stop bits |
| slave_sel_o | output | 1 | Pulse: winner addressed this node, switch to slave |

## Verification
The hardest case to reach from the ports is the hand-off to slave mode in the same byte in which arbitration was lost. It needs a START, then seven clocked bits on which the bench models a wired-AND of the node's drive and a foreign master's address. The loss must land either early in the byte or on the seventh bit itself. The bench builds this bit by bit on the raw pins and runs both loss positions, a matching address with no contention, and a mismatching winner. Bus-free timing is swept over several SCL low periods, and the loss condition is swept over all sixteen input combinations.

// File: rtl/i2c_arb_pkg.sv
// Package: shared types and constants for the arbitration monitor.
package i2c_arb_pkg;

    // State of the deferred-START gate
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_WAIT = 2'd1,
        GATE_FREE = 2'd2
    } gate_state_e;

    // Line indices inside the synchronizer bundle
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/i2c_bus_tracker.sv
// i2c_bus_tracker: synchronizes the raw SDA/SCL pins and derives START,
// STOP and SCL-rise events plus a bus-busy flag.
// Assumes: raw pins are asynchronous; SYNC_STAGES >= 2; pins idle high.
module i2c_bus_tracker
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_raw,
    input  logic scl_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det,
    output logic busy_q
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] synced;
    logic                 sda_p;
    logic                 scl_p;
    logic                 scl_s;

    assign raw_lines[LINE_SDA] = sda_raw;
    assign raw_lines[LINE_SCL] = scl_raw;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            // Purpose: shift the raw pin through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw_lines[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    assign sda_s = synced[LINE_SDA];
    assign scl_s = synced[LINE_SCL];

    // Purpose: keep last-cycle copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_p <= 1'b1;
            scl_p <= 1'b1;
        end else begin
            sda_p <= sda_s;
            scl_p <= scl_s;
        end
    end

    // Purpose: decode bus conditions from synchronized levels
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

    // Purpose: bus-busy flag between START and STOP
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (start_det) busy_q <= 1'b1;
        else if (stop_det)  busy_q <= 1'b0;
    end

    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_q);
    a_r1_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy_q);

endmodule

// File: rtl/i2c_start_gate.sv
// i2c_start_gate: grants a START at once on a free bus, or defers it until a
// foreign STOP plus a bus-free count equal to the SCL low period.
// Assumes: low_cnt >= 1; req is a one-cycle pulse.
module i2c_start_gate
    import i2c_arb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             mst_en,
    input  logic             lock,
    input  logic             cancel,
    input  logic             busy,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [CNT_W-1:0] low_cnt,
    output logic             go_q
);

    gate_state_e      state_q;
    logic [CNT_W-1:0] free_cnt_q;
    logic             allowed;

    assign allowed = mst_en & ~lock & ~cancel;

    // Purpose: sequence immediate or deferred START grants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= GATE_IDLE;
            free_cnt_q <= '0;
            go_q       <= 1'b0;
        end else begin
            go_q <= 1'b0;
            unique case (state_q)
                GATE_IDLE: begin
                    if (req && allowed) begin
                        if (busy) state_q <= GATE_WAIT;
                        else      go_q    <= 1'b1;
                    end
                end
                GATE_WAIT: begin
                    if (!allowed) begin
                        state_q <= GATE_IDLE;
                    end else if (stop_det) begin
                        state_q    <= GATE_FREE;
                        free_cnt_q <= CNT_W'(1);
                    end
                end
                GATE_FREE: begin
                    if (!allowed) begin
                        state_q <= GATE_IDLE;
                    end else if (start_det) begin
                        state_q <= GATE_WAIT;
                    end else if (free_cnt_q >= low_cnt) begin
                        go_q    <= 1'b1;
                        state_q <= GATE_IDLE;
                    end else begin
                        free_cnt_q <= free_cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= GATE_IDLE;
            endcase
        end
    end

    a_r8_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q);
    a_r7_go_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> $past(mst_en));

endmodule

// File: rtl/i2c_arb_checker.sv
// i2c_arb_checker: compares each node-driven bit with the line on the SCL
// rising edge and flags arbitration loss.
// Assumes: bit_valid is low on ACK bits the node receives.
module i2c_arb_checker (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic sda_s,
    input  logic sda_drive,
    input  logic bit_valid,
    input  logic mst_en,
    output logic lost_now,
    output logic lost_q
);

    // Purpose: released-one read back as zero on a driven bit
    always_comb begin
        lost_now = scl_rise & bit_valid & mst_en & sda_drive & ~sda_s;
    end

    // Purpose: register the loss as a one-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n) lost_q <= 1'b0;
        else        lost_q <= lost_now;
    end

    a_r2_loss_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |=> !lost_q);

endmodule

// File: rtl/i2c_addr_match.sv
// i2c_addr_match: collects the address bits after each START and reports a
// hand-off to slave mode when this node lost arbitration in the frame and
// the winner sends the node's own address.
// Assumes: address sent MSB first on the first ADDR_W SCL rises.
module i2c_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              scl_rise,
    input  logic              sda_s,
    input  logic              lost_now,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sel_q
);

    localparam int BCNT_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] shift_q;
    logic [BCNT_W-1:0] bit_cnt_q;
    logic              active_q;
    logic              lost_frame_q;
    logic [ADDR_W-1:0] addr_now;
    logic              last_bit;

    assign addr_now = {shift_q[ADDR_W-2:0], sda_s};
    assign last_bit = (bit_cnt_q == BCNT_W'(ADDR_W - 1));

    // Purpose: gather address bits and decide the slave hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q      <= '0;
            bit_cnt_q    <= '0;
            active_q     <= 1'b0;
            lost_frame_q <= 1'b0;
            sel_q        <= 1'b0;
        end else begin
            sel_q <= 1'b0;
            if (start_det) begin
                bit_cnt_q    <= '0;
                active_q     <= 1'b1;
                lost_frame_q <= 1'b0;
            end else if (scl_rise && active_q) begin
                shift_q   <= addr_now;
                bit_cnt_q <= bit_cnt_q + BCNT_W'(1);
                if (lost_now) lost_frame_q <= 1'b1;
                if (last_bit) begin
                    active_q <= 1'b0;
                    if ((addr_now == own_addr) && (lost_frame_q || lost_now))
                        sel_q <= 1'b1;
                end
            end
        end
    end

    a_r10_sel_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |=> !sel_q);

endmodule

// File: rtl/i2c_arb_monitor.sv
// i2c_arb_monitor: top level. Tracks bus busy, gates START requests with
// the bus-free time, detects arbitration loss and reports slave hand-off.
// Holds the halt, error and lockout flags.
// Assumes: start_req_i, err_clr_i, lock_clr_i are one-cycle pulses.
module i2c_arb_monitor #(
    parameter int ADDR_W      = 7,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_en_i,
    input  logic              sda_raw_i,
    input  logic              scl_raw_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [CNT_W-1:0]  scl_low_cnt_i,
    input  logic              start_req_i,
    input  logic              sda_drive_i,
    input  logic              bit_valid_i,
    input  logic              err_clr_i,
    input  logic              lock_clr_i,
    output logic              bus_busy_o,
    output logic              start_go_o,
    output logic              arb_lost_o,
    output logic              scl_halt_o,
    output logic              arb_err_o,
    output logic              tx_lock_o,
    output logic              fifo_flush_o,
    output logic              cmd_clear_o,
    output logic              slave_sel_o
);

    logic sda_s, scl_rise, start_det, stop_det, busy_q;
    logic lost_now, lost_q, go_q, sel_q;
    logic halt_q, err_q, lock_q;

    i2c_bus_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .sda_raw(sda_raw_i), .scl_raw(scl_raw_i),
        .sda_s(sda_s), .scl_rise(scl_rise),
        .start_det(start_det), .stop_det(stop_det), .busy_q(busy_q)
    );

    i2c_arb_checker u_arb (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .sda_s(sda_s),
        .sda_drive(sda_drive_i), .bit_valid(bit_valid_i), .mst_en(mst_en_i),
        .lost_now(lost_now), .lost_q(lost_q)
    );

    i2c_start_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .req(start_req_i), .mst_en(mst_en_i), .lock(lock_q), .cancel(lost_now),
        .busy(busy_q), .start_det(start_det), .stop_det(stop_det),
        .low_cnt(scl_low_cnt_i), .go_q(go_q)
    );

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .start_det(start_det), .scl_rise(scl_rise), .sda_s(sda_s),
        .lost_now(lost_now), .own_addr(own_addr_i), .sel_q(sel_q)
    );

    // Purpose: hold SCL generation off from a loss until the bus is released
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_q <= 1'b0;
        else if (lost_now) halt_q <= 1'b1;
        else if (stop_det) halt_q <= 1'b0;
    end

    // Purpose: sticky arbitration-error flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (lost_now)  err_q <= 1'b1;
        else if (err_clr_i) err_q <= 1'b0;
    end

    // Purpose: sticky TX lockout flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          lock_q <= 1'b0;
        else if (lost_now)   lock_q <= 1'b1;
        else if (lock_clr_i) lock_q <= 1'b0;
    end

    assign bus_busy_o   = busy_q;
    assign start_go_o   = go_q;
    assign arb_lost_o   = lost_q;
    assign fifo_flush_o = lost_q;
    assign cmd_clear_o  = lost_q;
    assign scl_halt_o   = halt_q;
    assign arb_err_o    = err_q;
    assign tx_lock_o    = lock_q;
    assign slave_sel_o  = sel_q;

    a_r4_halt_with_loss: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> scl_halt_o);
    a_r5_flags_with_loss: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> (arb_err_o && tx_lock_o));
    a_r6_lock_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_go_o && tx_lock_o));
    a_r10_sel_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        slave_sel_o |-> scl_halt_o);

endmodule

// File: tb/i2c_arb_monitor_tb.sv
`timescale 1ns/1ps
module i2c_arb_monitor_tb;

    localparam int ADDR_W = 7;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_en = 1'b0, sda_raw = 1'b1, scl_raw = 1'b1;
    logic [ADDR_W-1:0] own_addr = 7'h5A;
    logic [CNT_W-1:0]  low_cnt = 16'd3;
    logic start_req = 1'b0, sda_drive = 1'b1, bit_valid = 1'b0;
    logic err_clr = 1'b0, lock_clr = 1'b0;
    logic bus_busy, start_go, arb_lost, scl_halt, arb_err, tx_lock;
    logic fifo_flush, cmd_clear, slave_sel;

    int checks = 0;
    int errs = 0;

    always #4 clk = ~clk;

    i2c_arb_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mst_en_i(mst_en),
        .sda_raw_i(sda_raw), .scl_raw_i(scl_raw),
        .own_addr_i(own_addr), .scl_low_cnt_i(low_cnt),
        .start_req_i(start_req), .sda_drive_i(sda_drive),
        .bit_valid_i(bit_valid), .err_clr_i(err_clr), .lock_clr_i(lock_clr),
        .bus_busy_o(bus_busy), .start_go_o(start_go), .arb_lost_o(arb_lost),
        .scl_halt_o(scl_halt), .arb_err_o(arb_err), .tx_lock_o(tx_lock),
        .fifo_flush_o(fifo_flush), .cmd_clear_o(cmd_clear),
        .slave_sel_o(slave_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic sda, input logic scl);
        sda_raw = sda;
        scl_raw = scl;
        step(3);
    endtask

    task automatic bus_start();
        lines(1'b1, 1'b1);
        lines(1'b0, 1'b1);
    endtask

    task automatic bus_stop();
        bit_valid = 1'b0;
        lines(1'b0, 1'b0);
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
    endtask

    // one bit: SCL low with new SDA and drive info, then SCL high
    task automatic clock_bit(input logic sda, input logic drv, input logic vld);
        sda_drive = drv;
        bit_valid = vld;
        lines(sda, 1'b0);
        scl_raw = 1'b1;
        step(3);
    endtask

    task automatic clear_flags();
        err_clr = 1'b1;
        lock_clr = 1'b1;
        step(1);
        err_clr = 1'b0;
        lock_clr = 1'b0;
        step(1);
    endtask

    task automatic pulse_req();
        start_req = 1'b1;
        step(1);
        start_req = 1'b0;
    endtask

    // address frame: foreign master sends fa, node drives na when compete
    task automatic addr_frame(input logic [6:0] fa, input logic [6:0] na,
                              input logic compete, input logic exp_sel, input string tag);
        logic in_game;
        in_game = compete;
        bus_start();
        for (int b = 6; b >= 0; b--) begin
            logic drv, line;
            drv  = in_game ? na[b] : 1'b1;
            line = fa[b] & drv;
            clock_bit(line, drv, in_game);
            if (in_game && drv && !line) in_game = 1'b0;
            if (b == 1) chk({tag, " sel before last bit"}, slave_sel, 0);
        end
        chk(tag, slave_sel, exp_sel);
        step(1);
        chk({tag, " sel one cycle"}, slave_sel, 0);
        bus_stop();
        clear_flags();
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R12: reset state
        chk("R12 outputs after reset",
            {23'd0, bus_busy, start_go, arb_lost, scl_halt, arb_err, tx_lock,
             fifo_flush, cmd_clear, slave_sel}, 0);

        // R1: START/STOP tracking and SCL-low SDA changes
        lines(1'b0, 1'b1);
        chk("R1 busy after START", bus_busy, 1);
        lines(1'b1, 1'b1);
        chk("R1 idle after STOP", bus_busy, 0);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        chk("R1 no START with SCL low", bus_busy, 0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        chk("R1 still idle", bus_busy, 0);

        // R7: immediate start on free bus, none with master disabled
        mst_en = 1'b0;
        pulse_req();
        chk("R7 no go when master off", start_go, 0);
        mst_en = 1'b1;
        pulse_req();
        chk("R7 go right after request", start_go, 1);
        step(1);
        chk("R7 go one cycle", start_go, 0);

        // R8: deferred start, sweep bus-free length
        for (int l = 1; l <= 5; l++) begin
            low_cnt = CNT_W'(l);
            bus_start();
            pulse_req();
            chk("R8 no go while busy", start_go, 0);
            step(5);
            chk("R8 still waiting", start_go, 0);
            lines(1'b1, 1'b1);
            chk("R8 busy dropped, no go yet", {bus_busy, start_go}, 0);
            for (int j = 1; j <= l; j++) begin
                step(1);
                chk($sformatf("R8 free count L=%0d j=%0d", l, j), start_go, (j == l) ? 1 : 0);
            end
        end
        low_cnt = 16'd3;

        // R2/R3/R4/R5/R6: full sweep of the loss condition
        for (int c = 0; c < 16; c++) begin
            logic m, v, d, s, exp_l;
            {m, v, d, s} = 4'(c);
            exp_l = m & v & d & ~s;
            mst_en = m;
            bus_start();
            clock_bit(s, d, v);
            chk($sformatf("R2/R3 loss m%0d v%0d d%0d s%0d", m, v, d, s),
                {arb_lost, fifo_flush, cmd_clear}, {3{exp_l}});
            chk("R4 halt on loss", scl_halt, exp_l);
            step(1);
            chk("R2 loss one cycle", arb_lost, 0);
            bit_valid = 1'b0;
            if (exp_l) begin
                step(4);
                chk("R4 halt held", scl_halt, 1);
            end
            bus_stop();
            chk("R4 halt released by STOP", scl_halt, 0);
            chk("R5 error sticky", arb_err, exp_l);
            chk("R6 lock sticky", tx_lock, exp_l);
            if (exp_l) begin
                pulse_req();
                chk("R6 lock blocks go", start_go, 0);
                err_clr = 1'b1;
                step(1);
                err_clr = 1'b0;
                step(1);
                chk("R5 error cleared, lock kept", {arb_err, tx_lock}, 2'b01);
                lock_clr = 1'b1;
                step(1);
                lock_clr = 1'b0;
                step(1);
                chk("R6 lock cleared", tx_lock, 0);
                pulse_req();
                chk("R6 go after unlock", start_go, 1);
                step(1);
            end
        end
        mst_en = 1'b1;

        // R9: waiting request dropped by a loss
        bus_start();
        pulse_req();
        clock_bit(1'b0, 1'b1, 1'b1);
        chk("R9 loss while waiting", arb_lost, 1);
        bus_stop();
        clear_flags();
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 8; k++) begin
                step(1);
                if (start_go) seen++;
            end
            chk("R9 no go after STOP", seen, 0);
        end

        // R10/R11: slave hand-off
        addr_frame(7'h5A, 7'h7F, 1'b1, 1'b1, "R10 early loss own addr");
        addr_frame(7'h5A, 7'h5B, 1'b1, 1'b1, "R10 loss on last address bit");
        addr_frame(7'h5A, 7'h5A, 1'b0, 1'b0, "R11 own addr without loss");
        addr_frame(7'h3C, 7'h7F, 1'b1, 1'b0, "R11 loss other addr");
        own_addr = 7'h01;
        addr_frame(7'h01, 7'h41, 1'b1, 1'b1, "R10 second own addr");

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule